// File: doc/BRIEF.md
# Descriptor ring DMA controller

This block moves packet bytes between a shared word-addressed memory and two byte-wide streams. Software builds two circular lists of descriptors in that memory, one for sending and one for receiving. Each descriptor is four words: word 0 holds status, word 1 holds control, word 2 holds the buffer's byte address, and word 3 is unused. Software hands a descriptor to the controller by setting its ownership flag. The controller clears that flag when it has finished with the descriptor, and it writes back completion status at the same time.

Software sees a small register file. It holds the two ring base addresses, a run bit for each direction, a poll strobe for sending, a software reset and a read-only status word. The status word reports what each direction is doing. For sending, the controller reads the buffer bytes named by an owned descriptor and presents them on a valid/ready output. For receiving, it takes bytes from an input stream and stores them into the buffer of an owned descriptor. A single sequencer serves both directions, one descriptor at a time, and sending goes first when both are waiting.

Top module: `desc_ring_dma`

## Requirements
- R1: After reset, the status register (0x028) and the mode register (0x030) read zero, tx_valid is low and rx_ready is low.
- R2: A send descriptor whose status bit 31 is 1 streams bytes from its buffer in ascending byte address order, taking lane k of a memory word as byte address 4*word+k. The byte count is taken from control bits 10:0. The controller then writes the whole status word as zero, which clears ownership and leaves error bit 15 at 0. While tx_ready is low, tx_valid and tx_data hold.
- R3: After a descriptor whose control bit 25 is set, the ring pointer returns to the ring base address. Otherwise it advances by 16 bytes. The same rule applies to both rings.
- R4: If the send descriptor has status bit 31 at 0, sending suspends and the pointer does not move. A write to 0x008 makes the controller read the same descriptor again. The first byte is valid on the fourth clock edge after the edge that takes the write.
- R5: Mode bit 13 runs sending and mode bit 1 runs receiving. Only those bits are stored. Setting bit 13 while it is clear starts a descriptor fetch without any poll write.
- R6: A received frame ends with rx_last. Its bytes are written into the buffer, and then the status word is written as follows: bit 31 = 0, bits 29:16 = the count of all bytes received including the 4 trailing check bytes, bit 8 = 1, and all other bits 0.
- R7: If a frame is longer than the buffer size in control bits 10:0, status bit 15 is set and bytes past the size are not written.
- R8: If the receive descriptor is not owned when a frame starts, the whole frame is accepted and discarded, and the descriptor is left untouched. The first byte of the next frame re-reads it.
- R9: Writing 1 to bit 0 of 0x000 returns the registers, pointers and both processes to their reset state.
- R10: A send descriptor with control bit 27 set emits no bytes, yet it is still completed with its status written as zero.
- R11: Status bits 22:20 give the send state: 0 stopped, 1 descriptor access, 3 moving data, 6 suspended. Status bits 19:17 give the receive state: 0 stopped, 1 descriptor access, 3 waiting for a frame, 4 suspended, 7 moving data.
- R12: A direction whose run bit is clear fetches nothing. Receiving holds rx_ready low, and a poll write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Memory byte lane enables |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle as mem_addr |
| tx_valid | output | 1 | Send byte valid |
| tx_data | output | 8 | Send byte |
| tx_ready | input | 1 | Send byte taken |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of frame |
| rx_ready | output | 1 | Receive byte taken |

## Verification
The timing is fixed in clock edges. A poll write is taken on edge k. The state field shows 1 after edge k+1, and the first byte with state 3 appears after edge k+4, because the status, control and buffer words are read one per edge. The bench samples at falling edges on exactly those cycles. A receive frame waits three edges for its descriptor before the first byte is taken, and its status is written one edge after rx_last is accepted. The bench reads memory only after a margin of several cycles, so those checks do not depend on exact latency. Send bytes are collected at each falling edge where valid and ready are both high, and are compared against the expected buffer contents.

// File: rtl/desc_ring_dma.sv
module desc_ring_dma #(
  parameter int AW   = 10,
  parameter int SZW  = 11,
  parameter int LENW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  output logic          rx_ready
);
  localparam int BW = AW + 2;

  typedef enum logic [3:0] {
    S_IDLE, S_TSTAT, S_TCTRL, S_TBUF, S_TDATA, S_TWB,
    S_RSTAT, S_RCTRL, S_RBUF, S_RDATA, S_RWB, S_RDROP
  } st_t;

  st_t st;
  logic [BW-1:0]   tx_base, rx_base, tx_ptr, rx_ptr, bufa;
  logic            tx_run, rx_run, tx_pend, rx_susp, eor;
  logic [SZW-1:0]  size;
  logic [LENW-1:0] cnt;
  logic [2:0]      ts, rs;

  wire srst    = reg_we && reg_addr == 8'h00 && reg_wdata[0];
  wire wr_poll = reg_we && reg_addr == 8'h08;
  wire wr_rxb  = reg_we && reg_addr == 8'h18;
  wire wr_txb  = reg_we && reg_addr == 8'h20;
  wire wr_mode = reg_we && reg_addr == 8'h30;

  wire             in_tx = st >= S_TSTAT && st <= S_TWB;
  wire [BW-1:0]    cur   = in_tx ? tx_ptr : rx_ptr;
  wire [BW-1:0]    baddr = bufa + BW'(cnt);
  wire             fits  = cnt < LENW'(size);
  wire             owned = mem_rdata[31];

  assign tx_valid = st == S_TDATA && fits;
  assign tx_data  = 8'(mem_rdata >> {baddr[1:0], 3'b000});
  assign rx_ready = st == S_RDATA || st == S_RDROP;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 4'hf;
    mem_addr  = cur[BW-1:2];
    mem_wdata = '0;
    case (st)
      S_TSTAT, S_RSTAT: mem_en = 1'b1;
      S_TCTRL, S_RCTRL: begin mem_en = 1'b1; mem_addr = cur[BW-1:2] + AW'(1); end
      S_TBUF, S_RBUF:   begin mem_en = 1'b1; mem_addr = cur[BW-1:2] + AW'(2); end
      S_TDATA: begin
        mem_en   = fits;
        mem_addr = baddr[BW-1:2];
      end
      S_RDATA: begin
        mem_en    = rx_valid && fits;
        mem_we    = mem_en;
        mem_addr  = baddr[BW-1:2];
        mem_be    = 4'b0001 << baddr[1:0];
        mem_wdata = {4{rx_data}};
      end
      S_TWB: begin mem_en = 1'b1; mem_we = 1'b1; end
      S_RWB: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        mem_wdata[16 +: LENW] = cnt;
        mem_wdata[15] = cnt > LENW'(size);
        mem_wdata[8]  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE;
      tx_base <= '0; rx_base <= '0; tx_ptr <= '0; rx_ptr <= '0; bufa <= '0;
      tx_run <= 1'b0; rx_run <= 1'b0; tx_pend <= 1'b0; rx_susp <= 1'b0;
      eor <= 1'b0; size <= '0; cnt <= '0;
    end else begin
      if (wr_rxb) begin rx_base <= reg_wdata[BW-1:0]; rx_ptr <= reg_wdata[BW-1:0]; end
      if (wr_txb) begin tx_base <= reg_wdata[BW-1:0]; tx_ptr <= reg_wdata[BW-1:0]; end
      if (wr_mode) begin tx_run <= reg_wdata[13]; rx_run <= reg_wdata[1]; end
      case (st)
        S_IDLE:
          if (tx_run && tx_pend) st <= S_TSTAT;
          else if (rx_run && rx_valid) st <= S_RSTAT;
        S_TSTAT:
          if (owned) st <= S_TCTRL;
          else begin tx_pend <= 1'b0; st <= S_IDLE; end
        S_TCTRL: begin
          size <= mem_rdata[27] ? '0 : mem_rdata[SZW-1:0];
          eor  <= mem_rdata[25];
          cnt  <= '0;
          st   <= S_TBUF;
        end
        S_TBUF: begin bufa <= mem_rdata[BW-1:0]; st <= S_TDATA; end
        S_TDATA:
          if (!fits) st <= S_TWB;
          else if (tx_ready) cnt <= cnt + 1'b1;
        S_TWB: begin
          tx_ptr <= eor ? tx_base : tx_ptr + BW'(16);
          st     <= S_IDLE;
        end
        S_RSTAT:
          if (owned) begin rx_susp <= 1'b0; st <= S_RCTRL; end
          else begin rx_susp <= 1'b1; st <= S_RDROP; end
        S_RCTRL: begin
          size <= mem_rdata[SZW-1:0];
          eor  <= mem_rdata[25];
          cnt  <= '0;
          st   <= S_RBUF;
        end
        S_RBUF: begin bufa <= mem_rdata[BW-1:0]; st <= S_RDATA; end
        S_RDATA:
          if (rx_valid) begin
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (rx_last) st <= S_RWB;
          end
        S_RWB: begin
          rx_ptr <= eor ? rx_base : rx_ptr + BW'(16);
          st     <= S_IDLE;
        end
        S_RDROP:
          if (rx_valid && rx_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (wr_mode && !reg_wdata[13]) tx_pend <= 1'b0;
      else if ((wr_mode && reg_wdata[13] && !tx_run) || (wr_poll && tx_run)) tx_pend <= 1'b1;
    end
  end

  always_comb begin
    if (st == S_TDATA)      ts = 3'd3;
    else if (in_tx)         ts = 3'd1;
    else if (!tx_run)       ts = 3'd0;
    else if (tx_pend)       ts = 3'd1;
    else                    ts = 3'd6;
    if (st == S_RDATA)      rs = 3'd7;
    else if (st == S_RDROP) rs = 3'd4;
    else if (st == S_RSTAT || st == S_RCTRL || st == S_RBUF || st == S_RWB) rs = 3'd1;
    else if (!rx_run)       rs = 3'd0;
    else if (rx_susp)       rs = 3'd4;
    else                    rs = 3'd3;
  end

  always_comb begin
    case (reg_addr)
      8'h18:   reg_rdata = 32'(rx_base);
      8'h20:   reg_rdata = 32'(tx_base);
      8'h28:   reg_rdata = {9'b0, ts, rs, 17'b0};
      8'h30:   reg_rdata = {18'b0, tx_run, 11'b0, rx_run, 1'b0};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/desc_ring_dma_chk.sv
module desc_ring_dma_chk #(
  parameter int BW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic [3:0]    st,
  input logic          eor,
  input logic [BW-1:0] tx_ptr,
  input logic [BW-1:0] tx_base,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_ready,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic [2:0]    ts,
  input logic [2:0]    rs
);
  localparam logic [3:0] TBUF = 4'd3, TWB = 4'd5, RDATA = 4'd9;

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || srst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(st) == TBUF);

  assert_ring_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st) == TWB && $past(eor) && !$past(srst) |-> tx_ptr == tx_base);

  assert_lane_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && st == RDATA |-> $countones(mem_be) == 1);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> !tx_valid && !rx_ready && st == 4'd0);

  assert_state_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ts != 3'd2 && ts != 3'd4 && ts != 3'd5 && ts != 3'd7 &&
    rs != 3'd2 && rs != 3'd5 && rs != 3'd6);

  assert_one_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
endmodule

bind desc_ring_dma desc_ring_dma_chk #(.BW(AW + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .st(st), .eor(eor),
  .tx_ptr(tx_ptr), .tx_base(tx_base), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_ready(rx_ready), .mem_we(mem_we), .mem_be(mem_be),
  .ts(ts), .rs(rs)
);

// File: tb/desc_ring_dma_tb_top.sv
`timescale 1ns/1ps
module desc_ring_dma_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [7:0] reg_addr = 8'h28; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_en, mem_we; logic [3:0] mem_be; logic [9:0] mem_addr; logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_ready = 1; logic [7:0] tx_data;
  logic rx_valid = 0, rx_last = 0, rx_ready; logic [7:0] rx_data = 0;

  always #2.5 clk = ~clk;

  desc_ring_dma dut_i (.*);

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk)
    if (mem_en && mem_we)
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr][8*b +: 8] = mem_wdata[8*b +: 8];

  int total = 0, bad = 0, txn = 0;
  logic [7:0] txq [0:63];
  logic saw7 = 0;
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin if (txn < 64) txq[txn] = tx_data; txn++; end
    if (rx_valid && rx_ready && reg_addr == 8'h28 && reg_rdata[19:17] == 3'd7) saw7 = 1;
  end

  localparam logic [15:0] RXV [0:3] = '{ {8'd10, 8'd64}, {8'd5, 8'd64}, {8'd20, 8'd8}, {8'd7, 8'd6} };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 8'h28;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask
  function automatic logic [7:0] pat(input int a); return 8'(a) ^ 8'h5A; endfunction
  function automatic logic [7:0] fb(input int tag, input int i); return 8'(tag * 16 + i + 1); endfunction
  function automatic logic [7:0] mbyte(input int a); return mem[a >> 2][8*(a % 4) +: 8]; endfunction
  task automatic desc(input int a, input logic [31:0] s, input logic [31:0] c, input logic [31:0] b);
    mem[a >> 2] = s; mem[(a >> 2) + 1] = c; mem[(a >> 2) + 2] = b;
  endtask
  task automatic send_frame(input int n, input int tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = fb(tag, i); rx_last = (i == n - 1);
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask
  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n0, len, sz, keep;
    for (int w = 0; w < 1024; w++) mem[w] = 32'hEEEEEEEE;
    for (int a = 12'h800; a < 12'hA00; a++) mem[a >> 2][8*(a % 4) +: 8] = pat(a);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h28, d); chk("R1 status", d, 0);
    rd(8'h30, d); chk("R1 mode", d, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_ready", rx_ready, 0);

    for (int i = 0; i < 4; i++)
      desc(12'h100 + 16*i, 32'h8000_0000, 32'(RXV[i][7:0]) | (i == 3 ? 32'h0200_0000 : 0), 12'h400 + 12'h40*i);
    desc(12'h200, 32'h8000_0000, 32'h6000_0006, 32'h810);
    desc(12'h210, 32'h8000_0000, 32'h0A00_000C, 32'h840);
    wr(8'h18, 32'h100);
    wr(8'h20, 32'h200);
    wr(8'h30, 32'h2002);
    repeat (40) @(negedge clk);
    chk("R2 byte count", txn, 6);
    for (int i = 0; i < 6; i++) chk("R2 byte", txq[i], pat(12'h810 + i));
    chk("R2 status cleared", mem[12'h200 >> 2], 0);
    chk("R10 setup completed", mem[12'h210 >> 2], 0);
    rd(8'h28, d); chk("R4 suspended", d[22:20], 6);
    chk("R11 rx waiting", d[19:17], 3);

    desc(12'h200, 32'h8000_0000, 32'h6000_0003, 32'h903);
    repeat (5) @(negedge clk);
    chk("R4 no fetch without poll", txn, 6);
    tx_ready = 0;
    wr(8'h08, 1);
    @(negedge clk); rd(8'h28, d); chk("R11 descriptor access", d[22:20], 1);
    chk("R4 not yet valid", tx_valid, 0);
    @(negedge clk); @(negedge clk);
    chk("R4 not yet valid", tx_valid, 0);
    @(negedge clk);
    chk("R4 first byte on fourth edge", tx_valid, 1);
    rd(8'h28, d); chk("R11 moving data", d[22:20], 3);
    repeat (3) @(negedge clk);
    chk("R2 hold valid", tx_valid, 1);
    chk("R2 hold data", tx_data, pat(12'h903));
    tx_ready = 1;
    repeat (20) @(negedge clk);
    chk("R3 wrapped to base", txn, 9);
    for (int i = 0; i < 3; i++) chk("R3 bytes from first entry", txq[6 + i], pat(12'h903 + i));

    for (int i = 0; i < 4; i++) begin
      len = RXV[i][15:8]; sz = RXV[i][7:0];
      keep = len > sz ? sz : len;
      saw7 = 0;
      send_frame(len, i);
      repeat (8) @(negedge clk);
      chk("R6 rx status (length counts check bytes)", mem[(12'h100 + 16*i) >> 2],
          (32'(len) << 16) | (len > sz ? 32'h8000 : 0) | 32'h100);
      for (int j = 0; j < keep; j++) chk("R6 rx byte", mbyte(12'h400 + 12'h40*i + j), fb(i, j));
      if (len > sz) chk("R7 no write past size", mbyte(12'h400 + 12'h40*i + keep), 8'hEE);
      if (i == 0) chk("R11 rx moving data seen", saw7, 1);
    end

    send_frame(6, 5);
    repeat (4) @(negedge clk);
    rd(8'h28, d); chk("R8 rx suspended", d[19:17], 4);
    chk("R8 buffer untouched", mbyte(12'h400), fb(0, 0));
    chk("R8 descriptor untouched", mem[12'h100 >> 2], (32'd10 << 16) | 32'h100);
    mem[12'h100 >> 2] = 32'h8000_0000;
    send_frame(4, 6);
    repeat (8) @(negedge clk);
    chk("R3 rx wrap stored at base", mbyte(12'h400), fb(6, 0));
    chk("R8 resumed status", mem[12'h100 >> 2], (32'd4 << 16) | 32'h100);

    wr(8'h30, 0);
    rd(8'h30, d); chk("R5 mode cleared", d, 0);
    @(negedge clk); rx_valid = 1; rx_data = 8'h77;
    repeat (8) @(negedge clk);
    chk("R12 rx_ready low when stopped", rx_ready, 0);
    rd(8'h28, d); chk("R12 rx stopped", d[19:17], 0);
    rx_valid = 0;
    desc(12'h210, 32'h8000_0000, 32'h0200_0002, 32'h820);
    n0 = txn;
    wr(8'h08, 1);
    repeat (20) @(negedge clk);
    chk("R12 poll ignored when stopped", txn, n0);
    wr(8'h30, 32'h2000);
    repeat (20) @(negedge clk);
    chk("R5 start fetches", txn, n0 + 2);
    chk("R5 start byte", txq[n0], pat(12'h820));

    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, d); chk("R5 only run bits stored", d, 32'h2002);
    wr(8'h00, 1);
    rd(8'h30, d); chk("R9 mode reset", d, 0);
    rd(8'h28, d); chk("R9 status reset", d, 0);
    rd(8'h18, d); chk("R9 base reset", d, 0);
    chk("R9 tx_valid low", tx_valid, 0);
    finish_run();
  end
endmodule